// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages a bank of I/O pins that software and on-chip peripherals share. Each pin is either a software-controlled general-purpose pin or a pin owned by one of two dedicated peripheral functions. When software owns a pin, it can be an input, a push-pull output or an emulated open-drain output. When a peripheral owns a pin, that peripheral's output value and output enable drive the pad. Its input sink receives the synchronised pin level.

Software reaches five per-pin registers through a word-addressed interface with byte enables. The registers are ownership, direction, open-drain enable, function select and data. A data write is always kept in an internal output register. That value reaches the pad only when the pin is a software output. Each peripheral input sink that is not fed from its pin receives a fixed per-input default value. All pad outputs and peripheral sink outputs are registered. Pad inputs pass through a two-stage synchroniser.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every pin is a software-owned input, `pad_oe` is 0, and the ownership, direction, open-drain and select registers read 0.
- R2: Register offsets are ownership = 0, direction = 1, open-drain = 2, select = 3 and data = 4, with pin i at bit i. A write changes bit i only when `reg_be[i/8]` is set. Offsets 5 and up read 0, and writes to them change nothing.
- R3: A software-owned pin with direction 1 and open-drain 0 drives `pad_oe`=1, with `pad_out` equal to its stored data bit.
- R4: A software-owned pin with direction 1 and open-drain 1 drives `pad_out`=0, with `pad_oe` equal to the inverse of its stored data bit. It never drives a 1.
- R5: A software-owned pin with direction 0 has `pad_oe`=0 and `pad_out`=0. Data writes are still stored and appear on the pad once the pin becomes an output.
- R6: A data read returns the stored bit for a software output (push-pull or open-drain). For a software input or a peripheral-owned pin, it returns the synchronised pad level.
- R7: A peripheral-owned pin (ownership 1) takes `pad_out` and `pad_oe` from function 0 when select is 0 and from function 1 when select is 1. Direction and open-drain bits have no effect on it.
- R8: `alt0_in[i]` carries the synchronised pad level only while pin i is peripheral-owned with select 0, and `alt1_in[i]` only with select 1. Otherwise each carries its parameter default.
- R9: Pad outputs change one clock after the register write or peripheral input that causes them. A data read issued in the cycle a pad input changes, or in the next cycle, returns the old level. The read after that returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_be | input | DATA_W/8 | Byte enables for writes |
| reg_rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad driver enables |
| alt0_out | input | NUM_PINS | Function 0 output values |
| alt0_oe | input | NUM_PINS | Function 0 output enables |
| alt0_in | output | NUM_PINS | Function 0 input sinks |
| alt1_out | input | NUM_PINS | Function 1 output values |
| alt1_oe | input | NUM_PINS | Function 1 output enables |
| alt1_in | output | NUM_PINS | Function 1 input sinks |

## Verification
The main sweep gives every pin its own mixed configuration, so all five modes appear together in one bank. Across 64 sweep steps it varies the pad levels, the peripheral values and the stored data bits. The sweep shows whether each mode takes its drive from the right source: the stored bit, its inverse or a peripheral. It also shows whether the data read takes the stored bit or the pin, and whether each peripheral sink gets the pin or its default. Three directed sequences cover the rest. A data write made in input mode and later released by a direction change tests the shadow behaviour. Writes with an inactive byte lane and writes to reserved offsets test the ignore rules. Back-to-back reads around a pad change pin down the synchroniser delay, and checks one clock after a write pin down the output delay.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int REG_OWN  = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_ODE  = 2;
  localparam int REG_FSEL = 3;
  localparam int REG_DATA = 4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] sync_q
);
  logic [NUM_PINS-1:0] stage1;
  logic [1:0]          age;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      sync_q <= '0;
      age    <= '0;
    end else begin
      stage1 <= pad_in;
      sync_q <= stage1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  AST_SYNC_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (sync_q == $past(pad_in, 2))); // R9
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                re,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] own_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] ode_q,
  output logic [NUM_PINS-1:0] fsel_q,
  output logic [NUM_PINS-1:0] dout_q
);
  logic [NUM_PINS-1:0] lane_m;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] data_view;
  logic [DATA_W-1:0]   rd_next;
  logic                rsvd;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    assign lane_m[i] = be[i/8];
  end

  assign wbits = wdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= '0;
      dir_q  <= '0;
      ode_q  <= '0;
      fsel_q <= '0;
      dout_q <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(REG_OWN):  own_q  <= (own_q  & ~lane_m) | (wbits & lane_m);
        ADDR_W'(REG_DIR):  dir_q  <= (dir_q  & ~lane_m) | (wbits & lane_m);
        ADDR_W'(REG_ODE):  ode_q  <= (ode_q  & ~lane_m) | (wbits & lane_m);
        ADDR_W'(REG_FSEL): fsel_q <= (fsel_q & ~lane_m) | (wbits & lane_m);
        ADDR_W'(REG_DATA): dout_q <= (dout_q & ~lane_m) | (wbits & lane_m);
        default: ;
      endcase
    end
  end

  // Stored value for software outputs, live pin otherwise
  assign data_view = ((~own_q & dir_q) & dout_q) | (~(~own_q & dir_q) & pin_sync);
  assign rsvd      = (addr > ADDR_W'(REG_DATA));

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(REG_OWN):  rd_next = DATA_W'(own_q);
      ADDR_W'(REG_DIR):  rd_next = DATA_W'(dir_q);
      ADDR_W'(REG_ODE):  rd_next = DATA_W'(ode_q);
      ADDR_W'(REG_FSEL): rd_next = DATA_W'(fsel_q);
      ADDR_W'(REG_DATA): rd_next = DATA_W'(data_view);
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_next;
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(re && rsvd) |-> (rdata == '0)); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (own_q == '0 && dir_q == '0 && ode_q == '0)); // R1
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int                     NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0]    ALT0_DFLT = '0,
  parameter logic [NUM_PINS-1:0]    ALT1_DFLT = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] own,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] ode,
  input  logic [NUM_PINS-1:0] fsel,
  input  logic [NUM_PINS-1:0] dout,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] alt0_out,
  input  logic [NUM_PINS-1:0] alt0_oe,
  input  logic [NUM_PINS-1:0] alt1_out,
  input  logic [NUM_PINS-1:0] alt1_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] alt0_in,
  output logic [NUM_PINS-1:0] alt1_in
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic nx_out, nx_oe, take0, take1;

    assign take0 = own[i] & ~fsel[i];
    assign take1 = own[i] &  fsel[i];

    always_comb begin
      nx_out = 1'b0;
      nx_oe  = 1'b0;
      if (take0) begin
        nx_out = alt0_out[i];
        nx_oe  = alt0_oe[i];
      end else if (take1) begin
        nx_out = alt1_out[i];
        nx_oe  = alt1_oe[i];
      end else if (dir[i]) begin
        if (ode[i]) begin
          nx_out = 1'b0;
          nx_oe  = ~dout[i];
        end else begin
          nx_out = dout[i];
          nx_oe  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        alt0_in[i] <= ALT0_DFLT[i];
        alt1_in[i] <= ALT1_DFLT[i];
      end else begin
        pad_out[i] <= nx_out;
        pad_oe[i]  <= nx_oe;
        alt0_in[i] <= take0 ? pin_sync[i] : ALT0_DFLT[i];
        alt1_in[i] <= take1 ? pin_sync[i] : ALT1_DFLT[i];
      end
    end
  end

  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out) & $past(~own & ~dir)) == '0); // R5
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pad_out & $past(~own & dir & ode)) == '0); // R4
  AST_ALT0_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    ((alt0_in ^ ALT0_DFLT) & $past(~(own & ~fsel))) == '0); // R8
  AST_ALT1_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    ((alt1_in ^ ALT1_DFLT) & $past(~(own & fsel))) == '0); // R8
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int                  NUM_PINS  = 8,
  parameter int                  DATA_W    = 32,
  parameter int                  ADDR_W    = 3,
  parameter logic [NUM_PINS-1:0] ALT0_DFLT = '0,
  parameter logic [NUM_PINS-1:0] ALT1_DFLT = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W/8-1:0] reg_be,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt0_out,
  input  logic [NUM_PINS-1:0] alt0_oe,
  output logic [NUM_PINS-1:0] alt0_in,
  input  logic [NUM_PINS-1:0] alt1_out,
  input  logic [NUM_PINS-1:0] alt1_oe,
  output logic [NUM_PINS-1:0] alt1_in
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] own_q, dir_q, ode_q, fsel_q, dout_q;

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .sync_q(pin_sync)
  );

  gpio_mux_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .pin_sync(pin_sync), .rdata(reg_rdata),
    .own_q(own_q), .dir_q(dir_q), .ode_q(ode_q), .fsel_q(fsel_q), .dout_q(dout_q)
  );

  gpio_pin_mux #(.NUM_PINS(NUM_PINS), .ALT0_DFLT(ALT0_DFLT), .ALT1_DFLT(ALT1_DFLT)) u_mux (
    .clk(clk), .rst(rst), .own(own_q), .dir(dir_q), .ode(ode_q), .fsel(fsel_q),
    .dout(dout_q), .pin_sync(pin_sync),
    .alt0_out(alt0_out), .alt0_oe(alt0_oe), .alt1_out(alt1_out), .alt1_oe(alt1_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt0_in(alt0_in), .alt1_in(alt1_in)
  );
endmodule

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [N-1:0] DA = 8'h3C;
  localparam logic [N-1:0] DB = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW/8-1:0] be = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] a0o = '0, a0e = '0, a0i, a1o = '0, a1e = '0, a1i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mux_port #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW), .ALT0_DFLT(DA), .ALT1_DFLT(DB)) dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_re(re), .reg_addr(addr), .reg_wdata(wdata),
    .reg_be(be), .reg_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt0_out(a0o), .alt0_oe(a0e), .alt0_in(a0i),
    .alt1_out(a1o), .alt1_oe(a1e), .alt1_in(a1i)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Tasks start at a falling edge and end at a falling edge
  task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW/8-1:0] b);
    we = 1'b1; addr = AW'(a); wdata = d; be = b;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    re = 1'b1; addr = AW'(a);
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  function automatic logic [N-1:0] mix(input int c, input int k);
    return N'((c * 131 + k * 57) ^ (c * k * 7) ^ (c >> 1) ^ (k << 3));
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    logic [N-1:0] mo, di, od, fs, da, pi, xo, xe, xa, xb, xr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", DW'(pad_oe), '0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk("R1 reg", v, '0);
    end
    chk("R1 alt0_in default", DW'(a0i), DW'(DA));
    chk("R1 alt1_in default", DW'(a1i), DW'(DB));

    // R2 byte lanes and reserved offsets
    wr(1, 32'hFFFF_FFFF, 4'b1110);
    rd(1, v); chk("R2 inactive lane", v, '0);
    wr(1, 32'h0000_00A5, 4'b0001);
    rd(1, v); chk("R2 active lane", v, 32'hA5);
    for (int a = 5; a < 8; a++) begin
      wr(a, 32'hFFFF_FFFF, 4'hF);
      rd(a, v); chk("R2 reserved read", v, '0);
    end
    rd(1, v); chk("R2 reserved write no effect", v, 32'hA5);
    for (int a = 0; a < 4; a++) if (a != 1) begin
      rd(a, v); chk("R2 reserved write no effect", v, '0);
    end
    wr(1, 32'h0, 4'hF);
    @(negedge clk);

    // R5 shadow: data written while input is held, released by direction
    pad_in = 8'h00;
    wr(4, 32'h5A, 4'h1);
    @(negedge clk);
    chk("R5 input no drive oe", DW'(pad_oe), '0);
    chk("R5 input pad_out", DW'(pad_out), '0);
    rd(4, v); chk("R6 input reads pin", v, '0);
    wr(1, 32'hFF, 4'h1);
    // R9 one clock after write: still old
    chk("R9 output delay", DW'(pad_oe), '0);
    @(negedge clk);
    chk("R5 shadow released oe", DW'(pad_oe), 32'hFF);
    chk("R3 shadow released out", DW'(pad_out), 32'h5A);
    wr(1, 32'h0, 4'h1);
    @(negedge clk);

    // R9 input synchroniser delay
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hB7;
    rd(4, v); chk("R9 read same cycle old", v, '0);
    rd(4, v); chk("R9 read next cycle old", v, '0);
    rd(4, v); chk("R9 read third cycle new", v, 32'hB7);

    // Sweep over mixed per-pin configurations
    for (int c = 0; c < 64; c++) begin
      mo = mix(c, 1); di = mix(c, 2); od = mix(c, 3); fs = mix(c, 4);
      da = mix(c, 5); pi = mix(c, 6);
      wr(0, DW'(mo), 4'h1);
      wr(1, DW'(di), 4'h1);
      wr(2, DW'(od), 4'h1);
      wr(3, DW'(fs), 4'h1);
      wr(4, DW'(da), 4'h1);
      pad_in = pi;
      a0o = mix(c, 7); a0e = mix(c, 8); a1o = mix(c, 9); a1e = mix(c, 10);
      repeat (4) @(negedge clk);
      xe = (~mo & di & ~od) | (~mo & di & od & ~da) | (mo & ~fs & a0e) | (mo & fs & a1e);
      xo = (~mo & di & ~od & da) | (mo & ~fs & a0o) | (mo & fs & a1o);
      xa = (mo & ~fs & pi) | (~(mo & ~fs) & DA);
      xb = (mo & fs & pi) | (~(mo & fs) & DB);
      xr = (~mo & di & da) | (~(~mo & di) & pi);
      chk("R3 R4 R5 R7 pad_oe", DW'(pad_oe), DW'(xe));
      chk("R3 R4 R5 R7 pad_out", DW'(pad_out), DW'(xo));
      chk("R8 alt0_in", DW'(a0i), DW'(xa));
      chk("R8 alt1_in", DW'(a1i), DW'(xb));
      rd(4, v); chk("R6 data read", v, DW'(xr));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule